// File: doc/BRIEF.md
# Video Sync Alignment and Polarity Conditioner

This block sits in the path from a display timing generator to a video output port. On every pixel clock it takes one 24-bit pixel word together with a horizontal and a vertical sync strobe, and hands on a conditioned copy of all three. The pixel word and HSYNC always pass through a fixed four-stage pipeline. VSYNC passes through a tapped delay line, and a two-bit shift code picks which tap drives the output. VSYNC can therefore come out four or two clocks earlier than its received relation to HSYNC, keep that relation, or come out later by a programmed lag of 0 to 15 clocks. A receiver downstream uses this offset to tell odd fields from even ones.

Two further controls act at the output. A swap control exchanges the two low bytes of the pixel word, which swaps the chroma components of YUV data or the green and blue channels of RGB data. Two polarity controls invert HSYNC and VSYNC, but only while the 601 timing mode is enabled. Inversion is applied after alignment, so it never moves an edge. All configuration inputs are quasi-static. They act combinationally on the delayed data, so a change affects the output in the same cycle.

Top module: `sync_align_conditioner`

## Requirements
- R1: With `swap_en` = 1, `pix_out` equals the pixel word received 4 clocks earlier, with bits [7:0] and [15:8] exchanged and bits [23:16] unchanged.
- R2: With `swap_en` = 0, `pix_out` equals the pixel word received 4 clocks earlier, unchanged.
- R3: Before any inversion, `hs_out` equals `hs_in` as received 4 clocks earlier.
- R4: With `mode601` = 1, `hs_inv` = 1 inverts `hs_out` and `vs_inv` = 1 inverts `vs_out`. Inversion does not change the delay of either sync.
- R5: With `mode601` = 0, `hs_inv` and `vs_inv` have no effect on `hs_out` or `vs_out`.
- R6: Shift code 2'b00 gives VSYNC a delay of 0 clocks, so VSYNC leads HSYNC by 4 clocks.
- R7: Shift code 2'b01 gives VSYNC a delay of 2 clocks, so VSYNC leads HSYNC by 2 clocks.
- R8: Shift code 2'b10 gives VSYNC a delay of 4 clocks, so VSYNC keeps the alignment it was received with.
- R9: Shift code 2'b11 gives VSYNC a delay of 4 + `lag_cnt` clocks, for `lag_cnt` from 0 to 15, so VSYNC lags by `lag_cnt`.
- R10: A synchronous active-high `rst` clears every delay stage to sync-inactive (0) and zero pixel data. Stage contents seen after reset are therefore 0 before inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Exchange the two low bytes of the pixel |
| mode601 | input | 1 | 601 timing mode; gates sync inversion |
| hs_inv | input | 1 | Invert HSYNC output (601 mode only) |
| vs_inv | input | 1 | Invert VSYNC output (601 mode only) |
| shift_sel | input | 2 | VSYNC alignment code: 00 lead 4, 01 lead 2, 10 aligned, 11 lag |
| lag_cnt | input | 4 | Lag in clocks for shift code 11 |
| pix_in | input | 24 | Pixel word from the timing source |
| hs_in | input | 1 | HSYNC from the timing source |
| vs_in | input | 1 | VSYNC from the timing source |
| pix_out | output | 24 | Conditioned pixel word |
| hs_out | output | 1 | Conditioned HSYNC |
| vs_out | output | 1 | Conditioned VSYNC |

## Verification
The pixel word and HSYNC appear 4 clocks after they are sampled. VSYNC appears after 0, 2, 4 or 4 + lag clocks, depending on the shift code. Swap and inversion act in the same cycle as a configuration change. The bench drives inputs on the falling edge and indexes a per-cycle history of every driven input. One nanosecond before each rising edge it compares all three outputs against the history entry that lies exactly the expected number of cycles back, with the current configuration applied. Cycles before the end of reset count as zero. A wrong delay of even one clock, a wrong tap, or a misplaced inversion therefore shows up in the cycle where it occurs.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int LEAD_FULL = 4;
    localparam int LEAD_HALF = 2;

    typedef enum logic [1:0] {
        SH_LEAD4 = 2'b00,
        SH_LEAD2 = 2'b01,
        SH_ALIGN = 2'b10,
        SH_LAG   = 2'b11
    } vs_shift_e;

endpackage

// File: rtl/cond_lane_swap.sv
module cond_lane_swap #(
    parameter int PIX_W  = 24,
    parameter int LANE_W = 8
) (
    input  logic             swap,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o
);
    localparam int HI_W = PIX_W - 2 * LANE_W;

    logic [LANE_W-1:0] lane0, lane1;
    logic [HI_W-1:0]   upper;

    always_comb begin
        lane0 = pix_i[LANE_W-1:0];
        lane1 = pix_i[2*LANE_W-1:LANE_W];
        upper = pix_i[PIX_W-1:2*LANE_W];
        pix_o = swap ? {upper, lane0, lane1} : pix_i;
    end
endmodule

// File: rtl/cond_delay_line.sv
module cond_delay_line #(
    parameter int W     = 1,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       din,
    output logic [DEPTH*W-1:0] taps
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d        = line_q;
        line_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            line_d.stg[i] = line_q.stg[i-1];
        end
        if (rst) begin
            line_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        line_q <= line_d;
    end

    assign taps = line_q.stg;

    // R10: reset leaves every stage at zero
    a_r10_stages_cleared: assert property (@(posedge clk)
        rst |=> (line_q == '0));

    // R3: first stage captures the input of the previous clock
    a_r3_first_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (line_q.stg[0] == $past(din)));
endmodule

// File: rtl/cond_vs_select.sv
module cond_vs_select #(
    parameter int DEPTH = 19,
    parameter int DLY_W = 5
) (
    input  logic             vs_now,
    input  logic [DEPTH-1:0] taps,
    input  logic [DLY_W-1:0] delay,
    output logic             vs_sel
);
    always_comb begin
        vs_sel = vs_now;
        for (int k = 1; k <= DEPTH; k++) begin
            if (delay == DLY_W'(k)) begin
                vs_sel = taps[k-1];
            end
        end
    end
endmodule

// File: rtl/sync_align_conditioner.sv
module sync_align_conditioner
    import cond_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int LANE_W  = 8,
    parameter int LAG_MAX = 15,
    localparam int LAG_W  = $clog2(LAG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             swap_en,
    input  logic             mode601,
    input  logic             hs_inv,
    input  logic             vs_inv,
    input  logic [1:0]       shift_sel,
    input  logic [LAG_W-1:0] lag_cnt,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             hs_out,
    output logic             vs_out
);
    localparam int HW     = PIX_W + 1;
    localparam int HDEPTH = LEAD_FULL;
    localparam int VDEPTH = LEAD_FULL + LAG_MAX;
    localparam int DLY_W  = $clog2(VDEPTH + 1);

    logic [HDEPTH*HW-1:0] h_taps;
    logic [VDEPTH-1:0]    v_taps;
    logic [HW-1:0]        h_last;
    logic [PIX_W-1:0]     pix_core;
    logic                 hs_core;
    logic                 vs_core;
    logic [DLY_W-1:0]     vs_delay;
    logic [LAG_W-1:0]     lag_eff;
    vs_shift_e            shift_code;

    // pixel word and HSYNC share the fixed pipeline
    cond_delay_line #(.W(HW), .DEPTH(HDEPTH)) u_hline (
        .clk  (clk),
        .rst  (rst),
        .din  ({hs_in, pix_in}),
        .taps (h_taps)
    );

    assign h_last   = h_taps[HDEPTH*HW-1 -: HW];
    assign hs_core  = h_last[HW-1];
    assign pix_core = h_last[PIX_W-1:0];

    cond_lane_swap #(.PIX_W(PIX_W), .LANE_W(LANE_W)) u_swap (
        .swap  (swap_en),
        .pix_i (pix_core),
        .pix_o (pix_out)
    );

    // VSYNC tapped line
    cond_delay_line #(.W(1), .DEPTH(VDEPTH)) u_vline (
        .clk  (clk),
        .rst  (rst),
        .din  (vs_in),
        .taps (v_taps)
    );

    always_comb begin
        shift_code = vs_shift_e'(shift_sel);
        lag_eff    = (int'(lag_cnt) > LAG_MAX) ? LAG_W'(LAG_MAX) : lag_cnt;
        case (shift_code)
            SH_LEAD4: vs_delay = '0;
            SH_LEAD2: vs_delay = DLY_W'(LEAD_FULL - LEAD_HALF);
            SH_ALIGN: vs_delay = DLY_W'(LEAD_FULL);
            default:  vs_delay = DLY_W'(LEAD_FULL) + DLY_W'(lag_eff);
        endcase
    end

    cond_vs_select #(.DEPTH(VDEPTH), .DLY_W(DLY_W)) u_vsel (
        .vs_now (vs_in),
        .taps   (v_taps),
        .delay  (vs_delay),
        .vs_sel (vs_core)
    );

    // polarity after alignment
    always_comb begin
        hs_out = hs_core ^ (mode601 & hs_inv);
        vs_out = vs_core ^ (mode601 & vs_inv);
    end

    // cycles since reset, for the history-bounded checks below
    logic [2:0] warm_d, warm_q;
    always_comb begin
        warm_d = (warm_q == 3'd7) ? warm_q : warm_q + 3'd1;
        if (rst) warm_d = '0;
    end
    always_ff @(posedge clk) begin
        warm_q <= warm_d;
    end

    a_r3_hs_latency: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4) |-> (hs_core == $past(hs_in, 4)));

    a_r1_low_lane_swapped: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4 && swap_en) |->
        (pix_out[LANE_W-1:0] == $past(pix_in[2*LANE_W-1:LANE_W], 4)));

    a_r5_no_inversion: assert property (@(posedge clk) disable iff (rst)
        !mode601 |-> (hs_out == hs_core && vs_out == vs_core));

    a_r6_lead4: assert property (@(posedge clk) disable iff (rst)
        (shift_sel == 2'b00) |-> (vs_core == vs_in));

    a_r7_lead2: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd2 && shift_sel == 2'b01) |-> (vs_core == $past(vs_in, 2)));

    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4 && shift_sel == 2'b10) |-> (vs_core == $past(vs_in, 4)));

    a_r9_zero_lag: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4 && shift_sel == 2'b11 && lag_cnt == '0) |->
        (vs_core == $past(vs_in, 4)));
endmodule

// File: tb/sync_align_conditioner_bench.sv
module sync_align_conditioner_bench;
    localparam int PIX_W = 24;
    localparam int HIST  = 8192;

    logic             clk = 1'b0;
    logic             rst;
    logic             swap_en, mode601, hs_inv, vs_inv;
    logic [1:0]       shift_sel;
    logic [3:0]       lag_cnt;
    logic [PIX_W-1:0] pix_in;
    logic             hs_in, vs_in;
    logic [PIX_W-1:0] pix_out;
    logic             hs_out, vs_out;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    logic [PIX_W-1:0] h_pix [0:HIST-1];
    logic             h_hs  [0:HIST-1];
    logic             h_vs  [0:HIST-1];

    always #5 clk = ~clk;

    sync_align_conditioner u_sync_align_conditioner (
        .clk(clk), .rst(rst), .swap_en(swap_en), .mode601(mode601),
        .hs_inv(hs_inv), .vs_inv(vs_inv), .shift_sel(shift_sel),
        .lag_cnt(lag_cnt), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in),
        .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out)
    );

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [PIX_W-1:0] pix_at(int n);
        return (n < 0) ? '0 : h_pix[n];
    endfunction
    function automatic logic hs_at(int n);
        return (n < 0) ? 1'b0 : h_hs[n];
    endfunction
    function automatic logic vs_at(int n);
        return (n < 0) ? 1'b0 : h_vs[n];
    endfunction

    task automatic check(string req, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare just before rising edge
    task automatic step(bit in_reset, logic [PIX_W-1:0] p, logic h, logic v);
        int d;
        logic [PIX_W-1:0] ep;
        logic eh, ev;
        string rp, rh, rv;
        @(negedge clk);
        rst    = in_reset;
        pix_in = p; hs_in = h; vs_in = v;
        h_pix[cyc] = in_reset ? '0 : p;
        h_hs[cyc]  = in_reset ? 1'b0 : h;
        h_vs[cyc]  = in_reset ? 1'b0 : v;
        #4;
        case (shift_sel)
            2'b00:   begin d = 0;            rv = "R6"; end
            2'b01:   begin d = 2;            rv = "R7"; end
            2'b10:   begin d = 4;            rv = "R8"; end
            default: begin d = 4 + lag_cnt;  rv = "R9"; end
        endcase
        ep = pix_at(cyc - 4);
        if (swap_en) begin
            ep = {ep[23:16], ep[7:0], ep[15:8]};
            rp = "R1";
        end else begin
            rp = "R2";
        end
        eh = hs_at(cyc - 4) ^ (mode601 & hs_inv);
        ev = vs_at(cyc - d) ^ (mode601 & vs_inv);
        rh = mode601 ? (hs_inv ? "R4" : "R3") : ((hs_inv | vs_inv) ? "R5" : "R3");
        if (mode601 && vs_inv) rv = {rv, "/R4"};
        else if (!mode601 && vs_inv) rv = {rv, "/R5"};
        if (in_reset || cyc < 9) begin
            rp = {rp, "/R10"}; rh = {rh, "/R10"}; rv = {rv, "/R10"};
        end
        check({rp, " pix"}, pix_out, ep);
        check({rh, " hs"}, {{(PIX_W-1){1'b0}}, hs_out}, {{(PIX_W-1){1'b0}}, eh});
        check({rv, " vs"}, {{(PIX_W-1){1'b0}}, vs_out}, {{(PIX_W-1){1'b0}}, ev});
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, PIX_W'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        rst = 1'b1; swap_en = 0; mode601 = 0; hs_inv = 0; vs_inv = 0;
        shift_sel = 2'b10; lag_cnt = 0; pix_in = '0; hs_in = 0; vs_in = 0;
        // R10: reset state, outputs zero
        for (int i = 0; i < 5; i++) step(1'b1, '0, 1'b0, 1'b0);
        // R10: inverted inactive level right after reset in 601 mode
        mode601 = 1; hs_inv = 1; vs_inv = 1;
        step(1'b0, 24'h123456, 1'b1, 1'b1);
        mode601 = 0; hs_inv = 0; vs_inv = 0;

        // R2, R3, R8: plain pass-through, aligned sync
        run(150);
        // R1: byte swap
        swap_en = 1; run(150);
        // R6: lead by 4
        shift_sel = 2'b00; run(150);
        // R7: lead by 2
        shift_sel = 2'b01; run(150);
        // R5: inversion bits ignored outside 601 mode
        hs_inv = 1; vs_inv = 1; shift_sel = 2'b10; run(150);
        // R4: inversion in 601 mode, each sync separately then both
        mode601 = 1; hs_inv = 1; vs_inv = 0; run(100);
        hs_inv = 0; vs_inv = 1; shift_sel = 2'b01; run(100);
        hs_inv = 1; vs_inv = 1; swap_en = 0; run(100);
        // R9: lag sweep across the full range, inversion on and off
        shift_sel = 2'b11;
        for (int l = 0; l < 16; l++) begin
            lag_cnt = 4'(l);
            mode601 = l[0];
            run(60);
        end
        // R9 boundaries with isolated VSYNC pulses
        lag_cnt = 4'd15; mode601 = 0;
        for (int i = 0; i < 40; i++) step(1'b0, PIX_W'(i), 1'(i == 3), 1'(i == 5));
        lag_cnt = 4'd0;
        for (int i = 0; i < 40; i++) step(1'b0, PIX_W'(i), 1'(i == 3), 1'(i == 5));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule